// File: doc/BRIEF.md
# Two-Share Masked AND Without Fresh Randomness

This block computes a first-order Boolean-masked AND over `WIDTH` independent bit lanes. Each operand arrives as two shares. The first share carries the secret XORed with a mask. The second share carries only mask material, which is one of `m0`, `m1` or `m0 ^ m1`, and it never holds secret data. The gate consumes no random bits per operation. In place of a fresh mask it uses the single term `m0 | m1`, which is computed once from the two global mask bits and shared by all lanes. This works because, for any two different operand mask encodings, `a1 | b1` equals `m0 | m1`.

Each lane builds its result in three register levels, so the partial products are combined in a fixed order and glitches cannot merge them early. The first output share is `(a AND b) XOR x1`, where `x1` is the second share of whichever operand acts as the leading operand. The second output share is `x1` itself. The `swap_op` input chooses that leading operand, so the caller sets the output mask encoding to match the signal the result is combined with next. A valid strobe travels alongside the data with the same latency.

Top module: `zr_masked_and`

## Requirements
- R1: For every lane whose operand second shares satisfy `a1 | b1 == m0 | m1` (true whenever the two operands use different encodings from {m0, m1, m0^m1}), `q0 ^ q1` equals `(a0 ^ a1) & (b0 ^ b1)` of the inputs sampled three rising edges earlier.
- R2: When `swap_op` was 0 at sampling, `q1` equals the sampled `a1`, and `q0` equals the unmasked product XOR `a1`.
- R3: When `swap_op` was 1 at sampling, `q1` equals the sampled `b1`, and `q0` equals the unmasked product XOR `b1`.
- R4: `out_valid` equals `in_valid` sampled three rising edges earlier.
- R5: The shared `m0 | m1` term is captured together with the operands. As a result, `m0` and `m1` may change on every cycle without corrupting results already in the pipeline.
- R6: When `rst_n` is low at a rising edge, every pipeline register is cleared: `out_valid`, `q0` and `q1` read 0 after that edge, and for two edges after reset is released the reset-filled stages still present zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a valid input word |
| swap_op | input | 1 | 0: operand a leads and the output takes a's mask; 1: operand b leads and the output takes b's mask |
| a0 | input | WIDTH | First share of operand a per lane |
| a1 | input | WIDTH | Mask-only second share of operand a |
| b0 | input | WIDTH | First share of operand b per lane |
| b1 | input | WIDTH | Mask-only second share of operand b |
| m0 | input | 1 | Global mask bit 0 |
| m1 | input | 1 | Global mask bit 1 |
| out_valid | output | 1 | Valid strobe, delayed three cycles |
| q0 | output | WIDTH | First output share |
| q1 | output | WIDTH | Second output share, the leading operand's mask |

## Verification
The hardest case to reach from the ports is a mask change while earlier words are still in flight. In that case the shared OR term of one word must not leak into the stage-two combination of another. The stimulus changes `m0` and `m1` on every cycle and walks every ordered pair of distinct mask encodings for every plain operand value. It also gives each lane a different encoding pair in the same cycle. A mid-run reset then checks that the in-flight words are discarded.

// File: rtl/zr_mand_pkg.sv
// Package: shared constants for the masked AND pipeline.
// Assumes: nothing; consumed by all design modules and the checker.
package zr_mand_pkg;
    // Number of register levels from operand capture to output shares.
    localparam int ZR_LATENCY = 3;
endpackage

// File: rtl/zr_mask_term.sv
// Module: zr_mask_term
// Captures the shared term m0|m1 once for all lanes, on the same edge the
// lanes capture their operands, so the term travels with its data word.
// Assumes: m0/m1 are the global masks valid in the operand cycle.
module zr_mask_term (
    input  logic clk,
    input  logic rst_n,
    input  logic m0,
    input  logic m1,
    output logic mor_q
);
    // Register the OR of both global masks (stage one).
    always_ff @(posedge clk) begin
        if (!rst_n) mor_q <= 1'b0;
        else        mor_q <= m0 | m1;
    end
endmodule

// File: rtl/zr_valid_pipe.sv
// Module: zr_valid_pipe
// Delays the valid strobe by DEPTH register levels to match the data.
// Assumes: DEPTH >= 1.
module zr_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);
    logic [DEPTH-1:0] stg;

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            // Shift one valid bit per stage, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[i] <= 1'b0;
                else if (i == 0) stg[i] <= vin;
                else             stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign vout = stg[DEPTH-1];
endmodule

// File: rtl/zr_mand_lane.sv
// Module: zr_mand_lane
// One bit of the masked AND. The leading operand x is a (swap=0) or b
// (swap=1); y is the other one. Level 1 forms x0&y0, (x0&y1)^y1 and x1&y0;
// level 2 forms their sum and the correction with the shared OR term;
// level 3 joins both halves. The output is masked by x1 alone.
// Assumes: x1|y1 == m0|m1 (distinct encodings), mor_q captured with inputs.
module zr_mand_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic swap,
    input  logic a0,
    input  logic a1,
    input  logic b0,
    input  logic b1,
    input  logic mor_q,
    output logic q0,
    output logic q1
);
    logic x0, x1, y0, y1;
    logic p_aa, p_cross, p_mask, k1;
    logic s_left, s_right, k2;

    // Choose which operand leads, which fixes the output mask.
    always_comb begin
        x0 = swap ? b0 : a0;
        x1 = swap ? b1 : a1;
        y0 = swap ? a0 : b0;
        y1 = swap ? a1 : b1;
    end

    // Level 1: the three partial products, each in its own register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_aa    <= 1'b0;
            p_cross <= 1'b0;
            p_mask  <= 1'b0;
            k1      <= 1'b0;
        end else begin
            p_aa    <= x0 & y0;
            p_cross <= (x0 & y1) ^ y1;
            p_mask  <= x1 & y0;
            k1      <= x1;
        end
    end

    // Level 2: sum of the first-share terms, and mask term with the OR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_left  <= 1'b0;
            s_right <= 1'b0;
            k2      <= 1'b0;
        end else begin
            s_left  <= p_aa ^ p_cross;
            s_right <= p_mask ^ mor_q;
            k2      <= k1;
        end
    end

    // Level 3: join the halves; second share is the leading mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
        end else begin
            q0 <= s_left ^ s_right;
            q1 <= k2;
        end
    end
endmodule

// File: rtl/zr_masked_and.sv
// Module: zr_masked_and (top)
// WIDTH parallel first-order masked AND lanes sharing one m0|m1 term and
// one valid pipeline. No fresh randomness is consumed.
// Assumes: per lane, the operand second shares hold different encodings.
module zr_masked_and #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             swap_op,
    input  logic [WIDTH-1:0] a0,
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] b0,
    input  logic [WIDTH-1:0] b1,
    input  logic             m0,
    input  logic             m1,
    output logic             out_valid,
    output logic [WIDTH-1:0] q0,
    output logic [WIDTH-1:0] q1
);
    import zr_mand_pkg::*;

    logic mor_q;

    zr_mask_term u_term (
        .clk   (clk),
        .rst_n (rst_n),
        .m0    (m0),
        .m1    (m1),
        .mor_q (mor_q)
    );

    zr_valid_pipe #(.DEPTH(ZR_LATENCY)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .vout  (out_valid)
    );

    genvar l;
    generate
        for (l = 0; l < WIDTH; l++) begin : g_lane
            zr_mand_lane u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .swap  (swap_op),
                .a0    (a0[l]),
                .a1    (a1[l]),
                .b0    (b0[l]),
                .b1    (b1[l]),
                .mor_q (mor_q),
                .q0    (q0[l]),
                .q1    (q1[l])
            );
        end
    endgenerate
endmodule

// File: rtl/zr_masked_and_chk.sv
// Module: zr_masked_and_chk
// Temporal checks on the masked AND ports, bound into the top module.
// Assumes: the checks are only meaningful three edges after reset release.
module zr_masked_and_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             swap_op,
    input logic [WIDTH-1:0] a0,
    input logic [WIDTH-1:0] a1,
    input logic [WIDTH-1:0] b0,
    input logic [WIDTH-1:0] b1,
    input logic             m0,
    input logic             m1,
    input logic             out_valid,
    input logic [WIDTH-1:0] q0,
    input logic [WIDTH-1:0] q1
);
    logic [1:0]       live;
    logic [WIDTH-1:0] plain_ab;
    logic [WIDTH-1:0] enc_ok;
    logic [WIDTH-1:0] lead_mask;

    // Count edges with reset released, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)              live <= 2'd0;
        else if (live != 2'd3)   live <= live + 2'd1;
    end

    // Unmasked reference values and lane legality derived from the ports.
    always_comb begin
        plain_ab  = (a0 ^ a1) & (b0 ^ b1);
        enc_ok    = ~((a1 | b1) ^ {WIDTH{m0 | m1}});
        lead_mask = swap_op ? b1 : a1;
    end

    // R1 R5
    share_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd3) |-> ((((q0 ^ q1) ^ $past(plain_ab, 3)) & $past(enc_ok, 3)) == '0));

    // R2 R3
    out_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd3) |-> (q1 == $past(lead_mask, 3)));

    // R4
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (q0 == '0) && (q1 == '0)));
endmodule

bind zr_masked_and zr_masked_and_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .swap_op   (swap_op),
    .a0        (a0),
    .a1        (a1),
    .b0        (b0),
    .b1        (b1),
    .m0        (m0),
    .m1        (m1),
    .out_valid (out_valid),
    .q0        (q0),
    .q1        (q1)
);

// File: tb/zr_masked_and_bench.sv
// Bench: behavioural three-deep reference history compared every cycle.
module zr_masked_and_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         swap_op = 1'b0;
    logic [W-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
    logic         m0 = 1'b0, m1 = 1'b0;
    logic         out_valid;
    logic [W-1:0] q0, q1;

    integer n_chk = 0;
    integer n_bad = 0;
    integer cyc = 0;
    bit     done = 0;
    bit     comparing = 0;

    // Reference history: entry k is the word sampled k edges ago.
    logic         h_v  [3];
    logic         h_sw [3];
    logic [W-1:0] h_ab [3];
    logic [W-1:0] h_q1 [3];

    zr_masked_and #(.WIDTH(W)) u_zr_masked_and (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .swap_op(swap_op),
        .a0(a0), .a1(a1), .b0(b0), .b1(b1), .m0(m0), .m1(m1),
        .out_valid(out_valid), .q0(q0), .q1(q1)
    );

    always #2.5 clk = ~clk;

    // Mask value for encoding 1=m0, 2=m1, 3=m0^m1.
    function automatic logic enc_val(input int e, input logic k0, input logic k1);
        return (e == 1) ? k0 : (e == 2) ? k1 : (k0 ^ k1);
    endfunction

    // Model update on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        cyc = cyc + 1;
        for (int k = 2; k > 0; k--) begin
            h_v[k] = h_v[k-1]; h_sw[k] = h_sw[k-1];
            h_ab[k] = h_ab[k-1]; h_q1[k] = h_q1[k-1];
        end
        h_v[0]  = in_valid;
        h_sw[0] = swap_op;
        h_ab[0] = (a0 ^ a1) & (b0 ^ b1);
        h_q1[0] = swap_op ? b1 : a1;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                h_v[k] = 1'b0; h_sw[k] = 1'b0; h_ab[k] = '0; h_q1[k] = '0;
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (comparing && !done) begin
            chk("R4 out_valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, h_v[2]});
            chk(h_sw[2] ? "R3 q1 is b1" : "R2 q1 is a1", q1, h_q1[2]);
            chk(h_sw[2] ? "R3 q0 product^b1" : "R2 q0 product^a1", q0, h_ab[2] ^ h_q1[2]);
            chk("R1 R5 q0^q1 product", q0 ^ q1, h_ab[2]);
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        comparing = 1;
        // R6 reset state
        chk("R6 reset q0", q0, '0);
        chk("R6 reset q1", q1, '0);
        chk("R6 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
        rst_n = 1'b1;
        for (int sw = 0; sw < 2; sw++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 6; p++) begin
                    for (int v = 0; v < 4; v++) begin
                        // Masks shift each cycle too, exercising R5.
                        logic k0, k1;
                        k0 = m[0] ^ v[0];
                        k1 = m[1] ^ p[0];
                        @(negedge clk);
                        swap_op  = sw[0];
                        m0       = k0;
                        m1       = k1;
                        in_valid = (v != 3) || p[0];
                        for (int l = 0; l < W; l++) begin
                            int pp, ea, eb, kk, vv;
                            logic pa, pb, ma, mb;
                            pp = (p + l) % 6;
                            ea = pp / 2 + 1;
                            kk = pp % 2;
                            eb = (ea == 1) ? (kk ? 3 : 2) : (ea == 2) ? (kk ? 3 : 1) : (kk ? 2 : 1);
                            vv = (v + l) % 4;
                            pa = vv[0];
                            pb = vv[1];
                            ma = enc_val(ea, k0, k1);
                            mb = enc_val(eb, k0, k1);
                            a0[l] = pa ^ ma; a1[l] = ma;
                            b0[l] = pb ^ mb; b1[l] = mb;
                        end
                    end
                end
            end
        end
        // Mid-run reset: in-flight words must be discarded (R6).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 mid reset q0", q0, '0);
        chk("R6 mid reset q1", q1, '0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule